// File: doc/BRIEF.md
# Legacy Interrupt Message Aggregator

This block sits in a bridge between a downstream parallel bus and an upstream serial link. Several downstream devices can each raise or release any of four virtual legacy interrupt lines (A, B, C, D). The block merges these per-device events so that the upstream side sees exactly one assert message when a line goes from no holders to at least one holder. It sees exactly one deassert message when the last holder lets go.

Each line keeps a bitmap of the devices that hold it, indexed by device number. A per-line pending flag shows whether the bitmap is non-empty. The block accepts one event per clock through a valid/ready handshake. Each upstream transition goes into a small FIFO, and the FIFO presents the messages through a second valid/ready handshake in the order the transitions happened. Events that cause no transition complete locally and produce no message.

Top module: `irq_line_merge`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), every pending flag is 0, `msg_valid` is 0 and `evt_ready` is 1.
- R2: An accepted assert event (`evt_assert`=1) on line L (`evt_line` 0..3 meaning A..D) whose pending flag is 0 sets `line_pending[L]` after that clock edge. After the same edge it queues exactly one message with `msg_line`=L and `msg_assert`=1.
- R3: An accepted assert event on a line that is already pending queues no message and leaves the pending flag at 1.
- R4: A device is recorded at most once per line, so repeated asserts from the same device are undone by a single deassert from it.
- R5: An accepted deassert event (`evt_assert`=0) removes the device from the line's set. If other devices remain in the set, no message is queued and the flag stays 1.
- R6: When a deassert removes the last device of a line, `line_pending[L]` clears after that edge and exactly one message with `msg_line`=L and `msg_assert`=0 is queued.
- R7: A deassert from a device that is not in the line's set changes nothing. On an idle line it queues no message.
- R8: The four lines are independent. An event on one line never changes another line's set, flag or messages.
- R9: The message FIFO holds DEPTH (default 4) entries. `evt_ready` is 0 while it is full, and no event is accepted then, so no transition is lost.
- R10: Queued messages leave in the order their transitions occurred. While `msg_valid`=1 and `msg_ready`=0, `msg_line` and `msg_assert` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | Downstream event present |
| evt_ready | output | 1 | Event can be accepted (FIFO not full) |
| evt_line | input | 2 | Line index, 0=A .. 3=D |
| evt_assert | input | 1 | 1 = assert, 0 = deassert |
| evt_dev | input | 5 | Downstream device number 0..31 |
| msg_valid | output | 1 | Upstream message available |
| msg_ready | input | 1 | Upstream side takes the message |
| msg_line | output | 2 | Line of the head message |
| msg_assert | output | 1 | 1 = assert message, 0 = deassert message |
| line_pending | output | 4 | Per-line pending flag, bit L for line L |

## Verification
An event accepted at clock edge k shows its effect right after edge k. The new pending flags, the new `msg_valid` and the head message all belong to that same edge, and `evt_ready` reflects the FIFO occupancy left by it. A message popped at edge k disappears from the head right after edge k. The bench drives inputs on the falling edge. A queue-based model advances on the rising edge using only port-level inputs, and every output is compared at the following falling edge. So each comparison lands one half period after the edge that produced the expected value.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

   typedef enum logic {
      KIND_RELEASE = 1'b0,
      KIND_RAISE   = 1'b1
   } irq_kind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_line_tracker.sv
module irq_line_tracker #(
   parameter int unsigned NUM_DEVS = 32,
   parameter int unsigned DEV_W    = irq_merge_pkg::idx_width(NUM_DEVS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   input  logic             is_raise,
   input  logic [DEV_W-1:0] dev,
   output logic             pending,
   output logic             went_up,
   output logic             went_down
);

   logic [NUM_DEVS-1:0] holders_q, holders_d, dev_bit;
   logic                pend_q, pend_d;

   initial assert (NUM_DEVS >= 2 && NUM_DEVS <= 1024)
      else $error("irq_line_tracker: NUM_DEVS out of range");

   always_comb begin
      dev_bit = '0;
      dev_bit[dev] = 1'b1;
   end

   always_comb begin
      holders_d = holders_q;
      if (hit) begin
         if (is_raise) holders_d = holders_q | dev_bit;
         else          holders_d = holders_q & ~dev_bit;
      end
      pend_d = |holders_d;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         holders_q <= '0;
         pend_q    <= 1'b0;
      end else begin
         holders_q <= holders_d;
         pend_q    <= pend_d;
      end
   end

   assign pending   = pend_q;
   assign went_up   = !pend_q && pend_d;
   assign went_down = pend_q && !pend_d;

   // R4: a second raise from a device already recorded leaves the set unchanged
   p_dup_raise_r4: assert property (@(posedge clk) disable iff (rst)
      (hit && is_raise && |(holders_q & dev_bit)) |=> $stable(holders_q));

   // R7: releasing a device that is absent touches neither set nor flag
   p_ghost_release_r7: assert property (@(posedge clk) disable iff (rst)
      (hit && !is_raise && !(|(holders_q & dev_bit))) |=> ($stable(holders_q) && $stable(pend_q)));

   // R3: a raise on a pending line keeps it pending
   p_hold_pending_r3: assert property (@(posedge clk) disable iff (rst)
      (hit && is_raise && pend_q) |=> pend_q);

   // R2: any raise leaves the line pending
   p_raise_sets_r2: assert property (@(posedge clk) disable iff (rst)
      (hit && is_raise) |=> pend_q);

   // R8: no event for this line means the set does not move
   p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
      !hit |=> $stable(holders_q));

endmodule

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
   parameter int unsigned WIDTH = 3,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = irq_merge_pkg::idx_width(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q, wr_inc, rd_inc;
   logic [CNT_W-1:0] cnt_q;

   initial assert (DEPTH >= 2 && DEPTH <= 256 && WIDTH >= 1)
      else $error("irq_msg_fifo: bad DEPTH or WIDTH");

   generate
      if (POW2) begin : g_wrap_free
         assign wr_inc = wr_q + 1'b1;
         assign rd_inc = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_inc = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_inc = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign head  = mem[rd_q];

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_inc;
         if (pop)  rd_q <= rd_inc;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R9: never written while full
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);

   // R10: never read while empty
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

   // R10: head entry holds while it waits
   p_head_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!empty && !pop) |=> $stable(head));

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
   parameter int unsigned NUM_LINES = 4,
   parameter int unsigned NUM_DEVS  = 32,
   parameter int unsigned DEPTH     = 4,
   localparam int unsigned LINE_W   = irq_merge_pkg::idx_width(NUM_LINES),
   localparam int unsigned DEV_W    = irq_merge_pkg::idx_width(NUM_DEVS),
   localparam int unsigned MSG_W    = LINE_W + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 evt_valid,
   output logic                 evt_ready,
   input  logic [LINE_W-1:0]    evt_line,
   input  logic                 evt_assert,
   input  logic [DEV_W-1:0]     evt_dev,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [LINE_W-1:0]    msg_line,
   output logic                 msg_assert,
   output logic [NUM_LINES-1:0] line_pending
);

   import irq_merge_pkg::*;

   logic                 fire, q_full, q_empty, q_push, q_pop;
   logic [NUM_LINES-1:0] up_v, down_v;
   logic [MSG_W-1:0]     q_in, q_head;
   irq_kind_e            kind;

   initial assert (NUM_LINES >= 2 && NUM_LINES <= 64)
      else $error("irq_line_merge: NUM_LINES out of range");

   assign evt_ready = !q_full;
   assign fire      = evt_valid && evt_ready;
   assign kind      = evt_assert ? KIND_RAISE : KIND_RELEASE;

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         irq_line_tracker #(
            .NUM_DEVS (NUM_DEVS),
            .DEV_W    (DEV_W)
         ) u_trk (
            .clk       (clk),
            .rst       (rst),
            .hit       (fire && (evt_line == LINE_W'(i))),
            .is_raise  (kind == KIND_RAISE),
            .dev       (evt_dev),
            .pending   (line_pending[i]),
            .went_up   (up_v[i]),
            .went_down (down_v[i])
         );
      end
   endgenerate

   assign q_push = |(up_v | down_v);
   assign q_in   = {evt_line, |up_v};
   assign q_pop  = msg_ready && !q_empty;

   irq_msg_fifo #(
      .WIDTH (MSG_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (q_push),
      .push_data (q_in),
      .pop       (q_pop),
      .head      (q_head),
      .empty     (q_empty),
      .full      (q_full)
   );

   assign msg_valid  = !q_empty;
   assign msg_line   = q_head[MSG_W-1:1];
   assign msg_assert = q_head[0];

   // R8: one event moves at most one line
   p_single_change_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(up_v | down_v));

   // R9: a full queue refuses events
   p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
      q_full |-> !evt_ready);

   // R10: the offered message stays put while stalled
   p_msg_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_line) && $stable(msg_assert)));

   // R6: a flag falling always comes with a queued message
   p_fall_msg_r6: assert property (@(posedge clk) disable iff (rst)
      (fire && !evt_assert && line_pending[evt_line] && down_v == '0) |=> line_pending[$past(evt_line)]);

endmodule

// File: tb/irq_line_merge_tb.sv
module irq_line_merge_tb;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       evt_valid = 1'b0, evt_assert = 1'b0, msg_ready = 1'b1;
   logic [1:0] evt_line = '0;
   logic [4:0] evt_dev = '0;
   logic       evt_ready, msg_valid, msg_assert;
   logic [1:0] msg_line;
   logic [3:0] line_pending;

   int checks = 0, errors = 0, wd = 0;
   string cur_req = "R1";

   bit [31:0] m_set [4];
   bit [2:0]  m_q [$];

   always #10 clk = ~clk;

   irq_line_merge u_dut (
      .clk(clk), .rst(rst),
      .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_line(evt_line),
      .evt_assert(evt_assert), .evt_dev(evt_dev),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_line(msg_line),
      .msg_assert(msg_assert), .line_pending(line_pending)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit [3:0] m_pend();
      bit [3:0] p;
      for (int i = 0; i < 4; i++) p[i] = (m_set[i] != 0);
      return p;
   endfunction

   // reference model: advances on the rising edge from port inputs only
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 4; i++) m_set[i] = '0;
         m_q.delete();
      end else begin
         bit acc, was, now;
         acc = evt_valid && (m_q.size() < DEPTH);
         if (msg_ready && m_q.size() > 0) void'(m_q.pop_front());
         if (acc) begin
            was = (m_set[evt_line] != 0);
            if (evt_assert) m_set[evt_line][evt_dev] = 1'b1;
            else            m_set[evt_line][evt_dev] = 1'b0;
            now = (m_set[evt_line] != 0);
            if (was != now) m_q.push_back({evt_line, now});
         end
      end
   end

   // compare every cycle on the falling edge
   always @(negedge clk) begin
      if (!rst) begin
         chk(line_pending == m_pend(), cur_req, "pending", line_pending, m_pend());
         chk(evt_ready == (m_q.size() < DEPTH), cur_req, "evt_ready", evt_ready, m_q.size() < DEPTH);
         chk(msg_valid == (m_q.size() > 0), cur_req, "msg_valid", msg_valid, m_q.size() > 0);
         if (m_q.size() > 0)
            chk({msg_line, msg_assert} == m_q[0], cur_req, "msg head",
                {msg_line, msg_assert}, m_q[0]);
      end
   end

   task automatic send(input int line, input bit up, input int dev);
      @(negedge clk);
      evt_valid = 1'b1; evt_line = 2'(line); evt_assert = up; evt_dev = 5'(dev);
      while (!(m_q.size() < DEPTH)) @(negedge clk);
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
         finish_run();
      end
   end

   initial begin
      idle(3);
      chk(line_pending == 4'b0 && !msg_valid && evt_ready, "R1", "reset state",
          {line_pending, msg_valid, evt_ready}, 1);
      rst = 1'b0;
      idle(1);

      cur_req = "R2";
      send(0, 1, 3);
      idle(1);
      chk(line_pending[0] == 1'b1, "R2", "line A pending", line_pending[0], 1);

      cur_req = "R3";
      send(0, 1, 5);
      send(0, 1, 3);
      idle(1);
      chk(msg_valid == 1'b0, "R3", "no message on held line", msg_valid, 0);

      cur_req = "R4";
      send(1, 1, 7); send(1, 1, 7); send(1, 0, 7);
      idle(1);
      chk(line_pending[1] == 1'b0, "R4", "duplicate holder cleared once", line_pending[1], 0);

      cur_req = "R5";
      send(0, 0, 3);
      idle(1);
      chk(line_pending[0] == 1'b1, "R5", "A held by dev 5", line_pending[0], 1);

      cur_req = "R6";
      send(0, 0, 5);
      idle(1);
      chk(line_pending[0] == 1'b0, "R6", "A released", line_pending[0], 0);

      cur_req = "R7";
      send(2, 0, 9);
      idle(1);
      chk(msg_valid == 1'b0 && line_pending[2] == 1'b0, "R7", "ghost release idle",
          {msg_valid, line_pending[2]}, 0);
      send(3, 1, 2); send(3, 0, 1);
      idle(1);
      chk(line_pending[3] == 1'b1, "R7", "ghost release on held line", line_pending[3], 1);
      send(3, 0, 2);

      cur_req = "R8";
      send(1, 1, 0); send(2, 1, 31); send(1, 0, 0);
      idle(1);
      chk(line_pending == 4'b0100, "R8", "independent lines", line_pending, 4'b0100);
      send(2, 0, 31);

      cur_req = "R9";
      idle(2);
      msg_ready = 1'b0;
      for (int i = 0; i < 4; i++) send(i, 1, i);
      chk(evt_ready == 1'b0, "R9", "ready low when full", evt_ready, 0);
      fork
         send(0, 0, 0);
         begin
            idle(4);
            chk(line_pending[0] == 1'b1, "R9", "event held while full", line_pending[0], 1);
            cur_req = "R10";
            msg_ready = 1'b1;
         end
      join
      idle(8);
      chk(line_pending == 4'b1110 && !msg_valid, "R10", "drained in order",
          {line_pending, msg_valid}, 5'b11100);

      cur_req = "R8";
      for (int n = 0; n < 600; n++) begin
         msg_ready = ($urandom % 4) != 0;
         send($urandom % 4, $urandom % 2, $urandom % 6);
      end
      msg_ready = 1'b1;
      idle(10);
      finish_run();
   end

endmodule